// File: doc/BRIEF.md
# Banked Program Status Register

This block holds a processor's current status word together with a private saved copy for each of the five exception modes. On an exception it copies the current status into the saved copy that belongs to the target mode. In the same cycle it switches mode and raises the interrupt masks. An exception return copies the saved copy of the current mode back into the current status. A transfer port lets privileged code write or read either the current status or the saved copy of the current mode.

A condition-flag port takes the N, Z, C and V results from the datapath. A second output folds the flags, masks and low mode bits into the program counter word. Only the legacy 26-bit modes use this folded form; in the 32-bit modes that output carries the program counter as it is.

Top module: `psr_bank`

## Requirements
- R1: After reset the current status is 0x000000D3: mode SVC (5'b10011), IRQ mask (bit 7) set, FIQ mask (bit 6) set, flags (bits 31..28) clear. All five saved copies read 0.
- R2: A flag update (`flag_we`) loads `flag_in` into bits 31..28 in any mode and leaves the other bits unchanged.
- R3: An exception request takes effect only when its target is FIQ 5'b10001, IRQ 5'b10010, SVC 5'b10011, ABT 5'b10111 or UND 5'b11011. It writes the old current status into that mode's saved copy. In the same cycle it loads the target mode into bits 4..0 and sets bit 7, and it sets bit 6 as well for FIQ. Any other target is ignored.
- R4: An exception return loads the current status from the saved copy of the current mode. It is ignored in modes that have no saved copy.
- R5: In a privileged mode, a transfer write to the current status loads bits 31..28, 7, 6 and 4..0; every other bit reads 0. If the written mode code is not one of the ten legal codes, the mode field keeps its old value. Legal codes: 5'b00000, 5'b00001, 5'b00010, 5'b00011, 5'b10000, 5'b10001, 5'b10010, 5'b10011, 5'b10111, 5'b11011.
- R6: With `xfer_saved` high, a transfer write goes to the saved copy of the current mode, using the same bit masking and mode-field rule as R5. With `xfer_saved` high, `xfer_rdata` returns that saved copy; with it low, it returns the current status.
- R7: In user modes (5'b10000, 5'b00000), a transfer write to the current status changes only bits 31..28. Saved-copy writes and exception returns are ignored, and a saved-copy read returns 0. The 26-bit privileged modes (low mode bit 4) also have no saved copy.
- R8: When mode bit 4 is 0, `r15_view` is {flags, bit 7, bit 6, pc_in[25:2], mode[1:0]}. When mode bit 4 is 1, it equals `pc_in`.
- R9: Within one cycle, a valid exception request overrides return, transfer writes and flag update. An effective return overrides transfer writes and flag update. A transfer write to the current status overrides a flag update.
- R10: Each exception mode's saved copy is separate: writing one leaves the others unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flag_we | input | 1 | Load new condition flags |
| flag_in | input | 4 | New N, Z, C, V |
| exc_req | input | 1 | Exception entry request |
| exc_mode | input | 5 | Target mode of the exception |
| exc_ret | input | 1 | Exception return with status restore |
| xfer_we | input | 1 | Transfer write strobe |
| xfer_saved | input | 1 | Transfer targets the saved copy (1) or the current status (0) |
| xfer_wdata | input | 32 | Transfer write data |
| xfer_rdata | output | 32 | Transfer read data |
| pc_in | input | 32 | Program counter value |
| r15_view | output | 32 | Program counter word, folded with status in 26-bit modes |
| cpsr_o | output | 32 | Current status word |

## Verification
The bench steers the block through SVC, IRQ, FIQ, user and both 26-bit mode families, so each mode's saved copy is written and later read back. This separates a correct bank index from a shared or mis-indexed copy. Some cycles raise several strobes at once, which shows whether the priority order holds. Transfer data with stray bits and with an illegal mode code tests the masking and the mode-keep rule. Writes attempted from user mode show whether the privilege gate is applied or missing.

// File: rtl/psr_pkg.sv
package psr_pkg;
  localparam int PSR_W     = 32;
  localparam int MODE_W    = 5;
  localparam int NUM_SAVED = 5;
  localparam int SAVED_IW  = $clog2(NUM_SAVED);
  localparam int FLAG_LSB  = 28;
  localparam int IRQ_BIT   = 7;
  localparam int FIQ_BIT   = 6;

  localparam logic [PSR_W-1:0] IMPL_MASK = 32'hF000_00DF;

  localparam logic [MODE_W-1:0] MD_USR26 = 5'b00000;
  localparam logic [MODE_W-1:0] MD_FIQ26 = 5'b00001;
  localparam logic [MODE_W-1:0] MD_IRQ26 = 5'b00010;
  localparam logic [MODE_W-1:0] MD_SVC26 = 5'b00011;
  localparam logic [MODE_W-1:0] MD_USR   = 5'b10000;
  localparam logic [MODE_W-1:0] MD_FIQ   = 5'b10001;
  localparam logic [MODE_W-1:0] MD_IRQ   = 5'b10010;
  localparam logic [MODE_W-1:0] MD_SVC   = 5'b10011;
  localparam logic [MODE_W-1:0] MD_ABT   = 5'b10111;
  localparam logic [MODE_W-1:0] MD_UND   = 5'b11011;

  localparam logic [PSR_W-1:0] RESET_PSR =
    (PSR_W'(1) << IRQ_BIT) | (PSR_W'(1) << FIQ_BIT) | PSR_W'(MD_SVC);

  typedef struct packed {
    logic                valid;
    logic [SAVED_IW-1:0] idx;
  } slot_t;

  function automatic logic mode_legal(input logic [MODE_W-1:0] m);
    case (m)
      MD_USR26, MD_FIQ26, MD_IRQ26, MD_SVC26,
      MD_USR, MD_FIQ, MD_IRQ, MD_SVC, MD_ABT, MD_UND: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  // Only the five 32-bit exception modes own a saved copy.
  function automatic slot_t mode_slot(input logic [MODE_W-1:0] m);
    slot_t s;
    s.valid = 1'b1;
    case (m)
      MD_FIQ:  s.idx = SAVED_IW'(0);
      MD_IRQ:  s.idx = SAVED_IW'(1);
      MD_SVC:  s.idx = SAVED_IW'(2);
      MD_ABT:  s.idx = SAVED_IW'(3);
      MD_UND:  s.idx = SAVED_IW'(4);
      default: begin s.valid = 1'b0; s.idx = '0; end
    endcase
    return s;
  endfunction

  // Mask unimplemented bits; an illegal mode code keeps the old mode.
  function automatic logic [PSR_W-1:0] psr_merge(input logic [PSR_W-1:0] wr,
                                                 input logic [PSR_W-1:0] old);
    logic [PSR_W-1:0] r;
    r = wr & IMPL_MASK;
    if (!mode_legal(wr[MODE_W-1:0])) r[MODE_W-1:0] = old[MODE_W-1:0];
    return r;
  endfunction

  function automatic logic [PSR_W-1:0] r15_fold(input logic [PSR_W-1:0] psr,
                                                input logic [PSR_W-1:0] pc);
    return {psr[PSR_W-1:FLAG_LSB], psr[IRQ_BIT], psr[FIQ_BIT], pc[25:2], psr[1:0]};
  endfunction
endpackage

// File: rtl/psr_mode_decode.sv
module psr_mode_decode
  import psr_pkg::*;
(
  input  logic [MODE_W-1:0]   mode,
  output logic                has_slot,
  output logic [SAVED_IW-1:0] slot_idx,
  output logic                is26,
  output logic                is_user
);
  slot_t s;
  always_comb begin
    s        = mode_slot(mode);
    has_slot = s.valid;
    slot_idx = s.idx;
    is26     = ~mode[MODE_W-1];
    is_user  = (mode == MD_USR) || (mode == MD_USR26);
  end
endmodule

// File: rtl/psr_saved_bank.sv
module psr_saved_bank #(
  parameter int W   = 32,
  parameter int NUM = 5,
  localparam int IW = (NUM > 1) ? $clog2(NUM) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [IW-1:0] wr_idx,
  input  logic [W-1:0]  wr_data,
  input  logic [IW-1:0] rd_idx,
  output logic [W-1:0]  rd_data
);
  logic [W-1:0]   slot_q [NUM];
  logic [NUM-1:0] slot_we;

  for (genvar g = 0; g < NUM; g++) begin : g_slot
    assign slot_we[g] = we && (wr_idx == IW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          slot_q[g] <= '0;
      else if (slot_we[g]) slot_q[g] <= wr_data;
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM; i++)
      if (rd_idx == IW'(i)) rd_data = slot_q[i];
  end
endmodule

// File: rtl/psr_r15_view.sv
module psr_r15_view
  import psr_pkg::*;
(
  input  logic [PSR_W-1:0] psr,
  input  logic [PSR_W-1:0] pc,
  input  logic             is26,
  output logic [PSR_W-1:0] r15
);
  always_comb r15 = is26 ? r15_fold(psr, pc) : pc;
endmodule

// File: rtl/psr_bank.sv
module psr_bank
  import psr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flag_we,
  input  logic [3:0]        flag_in,
  input  logic              exc_req,
  input  logic [4:0]        exc_mode,
  input  logic              exc_ret,
  input  logic              xfer_we,
  input  logic              xfer_saved,
  input  logic [31:0]       xfer_wdata,
  output logic [31:0]       xfer_rdata,
  input  logic [31:0]       pc_in,
  output logic [31:0]       r15_view,
  output logic [31:0]       cpsr_o
);
  logic [PSR_W-1:0]    cpsr_q, cpsr_d;
  logic                cur_has_slot, cur_is26, cur_user;
  logic [SAVED_IW-1:0] cur_idx;
  slot_t               exc_slot;
  logic [PSR_W-1:0]    saved_rd;

  // Named internal events
  logic exc_fire, ret_fire, xfer_cur, xfer_sav, flag_fire;
  logic             bank_we;
  logic [SAVED_IW-1:0] bank_widx;
  logic [PSR_W-1:0] bank_wdata;

  psr_mode_decode u_dec (
    .mode(cpsr_q[MODE_W-1:0]), .has_slot(cur_has_slot), .slot_idx(cur_idx),
    .is26(cur_is26), .is_user(cur_user)
  );

  assign exc_slot  = mode_slot(exc_mode);
  assign exc_fire  = exc_req && exc_slot.valid;
  assign ret_fire  = !exc_fire && exc_ret && cur_has_slot;
  assign xfer_cur  = !exc_fire && !ret_fire && xfer_we && !xfer_saved;
  assign xfer_sav  = !exc_fire && !ret_fire && xfer_we && xfer_saved && cur_has_slot;
  assign flag_fire = !exc_fire && !ret_fire && !xfer_cur && flag_we;

  assign bank_we    = exc_fire || xfer_sav;
  assign bank_widx  = exc_fire ? exc_slot.idx : cur_idx;
  assign bank_wdata = exc_fire ? cpsr_q : psr_merge(xfer_wdata, saved_rd);

  psr_saved_bank #(.W(PSR_W), .NUM(NUM_SAVED)) u_bank (
    .clk(clk), .rst_n(rst_n), .we(bank_we), .wr_idx(bank_widx),
    .wr_data(bank_wdata), .rd_idx(cur_idx), .rd_data(saved_rd)
  );

  always_comb begin
    cpsr_d = cpsr_q;
    if (exc_fire) begin
      cpsr_d[MODE_W-1:0] = exc_mode;
      cpsr_d[IRQ_BIT]    = 1'b1;
      if (exc_mode == MD_FIQ) cpsr_d[FIQ_BIT] = 1'b1;
    end else if (ret_fire) begin
      cpsr_d = saved_rd;
    end else if (xfer_cur) begin
      if (cur_user) cpsr_d[PSR_W-1:FLAG_LSB] = xfer_wdata[PSR_W-1:FLAG_LSB];
      else          cpsr_d = psr_merge(xfer_wdata, cpsr_q);
    end else if (flag_fire) begin
      cpsr_d[PSR_W-1:FLAG_LSB] = flag_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cpsr_q <= RESET_PSR;
    else        cpsr_q <= cpsr_d;
  end

  psr_r15_view u_r15 (.psr(cpsr_q), .pc(pc_in), .is26(cur_is26), .r15(r15_view));

  assign xfer_rdata = xfer_saved ? (cur_has_slot ? saved_rd : '0) : cpsr_q;
  assign cpsr_o     = cpsr_q;

  assert_entry_mode_R3: assert property (@(posedge clk) disable iff (!rst_n)
    exc_fire |=> cpsr_q[MODE_W-1:0] == $past(exc_mode));
  assert_entry_mask_R3: assert property (@(posedge clk) disable iff (!rst_n)
    exc_fire |=> cpsr_q[IRQ_BIT]);
  assert_return_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ret_fire |=> cpsr_q == $past(saved_rd));
  assert_mode_legal_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |-> mode_legal(cpsr_q[MODE_W-1:0]));
  assert_user_locked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_user && !exc_fire) |=> cpsr_q[7:0] == $past(cpsr_q[7:0]));
  assert_r15_fold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cur_is26 |-> (r15_view[31:28] == cpsr_q[31:28] && r15_view[27] == cpsr_q[IRQ_BIT]));
  assert_entry_over_flags_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_fire && flag_we) |=> cpsr_q[31:28] == $past(cpsr_q[31:28]));
endmodule

// File: tb/psr_bank_tb.sv
module psr_bank_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic flag_we = 0, exc_req = 0, exc_ret = 0, xfer_we = 0, xfer_saved = 0;
  logic [3:0]  flag_in = 0;
  logic [4:0]  exc_mode = 0;
  logic [31:0] xfer_wdata = 0, pc_in = 0;
  logic [31:0] xfer_rdata, r15_view, cpsr_o;

  always #4 clk = ~clk; // 125 MHz

  psr_bank dut_i (
    .clk(clk), .rst_n(rst_n), .flag_we(flag_we), .flag_in(flag_in),
    .exc_req(exc_req), .exc_mode(exc_mode), .exc_ret(exc_ret),
    .xfer_we(xfer_we), .xfer_saved(xfer_saved), .xfer_wdata(xfer_wdata),
    .xfer_rdata(xfer_rdata), .pc_in(pc_in), .r15_view(r15_view), .cpsr_o(cpsr_o)
  );

  typedef struct {
    string       tag;
    logic [31:0] cpsr, rdata, r15;
  } item_t;

  item_t q[$];
  int checks = 0, fails = 0;
  bit done = 0;

  logic [31:0] e_cur;
  logic [31:0] e_sav [5];

  function automatic int b_slot(input logic [4:0] m);
    case (m)
      5'b10001: return 0;
      5'b10010: return 1;
      5'b10011: return 2;
      5'b10111: return 3;
      5'b11011: return 4;
      default:  return -1;
    endcase
  endfunction

  function automatic bit b_legal(input logic [4:0] m);
    return (m inside {5'b00000, 5'b00001, 5'b00010, 5'b00011, 5'b10000,
                      5'b10001, 5'b10010, 5'b10011, 5'b10111, 5'b11011});
  endfunction

  task automatic op(input string tag, input logic fw, input logic [3:0] f,
                    input logic er, input logic [4:0] em, input logic rt,
                    input logic xw, input logic xs, input logic [31:0] xd,
                    input logic [31:0] pc);
    logic [31:0] nxt;
    logic [31:0] nsav [5];
    int cs, es;
    bit ex, rf, usr;
    item_t it;
    @(negedge clk);
    flag_we = fw; flag_in = f; exc_req = er; exc_mode = em; exc_ret = rt;
    xfer_we = xw; xfer_saved = xs; xfer_wdata = xd; pc_in = pc;
    cs  = b_slot(e_cur[4:0]);
    es  = b_slot(em);
    usr = (e_cur[4:0] == 5'b10000) || (e_cur[4:0] == 5'b00000);
    ex  = er && (es >= 0);
    rf  = !ex && rt && (cs >= 0);
    nxt = e_cur;
    nsav = e_sav;
    if (ex) begin
      nsav[es] = e_cur;
      nxt[4:0] = em; nxt[7] = 1'b1;
      if (em == 5'b10001) nxt[6] = 1'b1;
    end else if (rf) begin
      nxt = e_sav[cs];
    end else if (xw && !xs) begin
      if (usr) nxt[31:28] = xd[31:28];
      else begin
        nxt = {xd[31:28], 20'h0, xd[7:6], 1'b0, xd[4:0]};
        if (!b_legal(xd[4:0])) nxt[4:0] = e_cur[4:0];
      end
    end else begin
      if (fw) nxt[31:28] = f;
      if (xw && xs && cs >= 0) begin
        nsav[cs] = {xd[31:28], 20'h0, xd[7:6], 1'b0, xd[4:0]};
        if (!b_legal(xd[4:0])) nsav[cs][4:0] = e_sav[cs][4:0];
      end
    end
    @(posedge clk);
    e_cur = nxt;
    e_sav = nsav;
    #1;
    cs = b_slot(e_cur[4:0]);
    it.tag   = tag;
    it.cpsr  = e_cur;
    it.rdata = xs ? ((cs >= 0) ? e_sav[cs] : 32'h0) : e_cur;
    it.r15   = e_cur[4] ? pc : {e_cur[31:28], e_cur[7], e_cur[6], pc[25:2], e_cur[1:0]};
    q.push_back(it);
  endtask

  task automatic idle(input string tag, input logic xs, input logic [31:0] pc);
    op(tag, 0, 4'h0, 0, 5'h0, 0, 0, xs, 32'h0, pc);
  endtask

  // Monitor: compares each expected item once outputs have settled.
  initial forever begin
    @(posedge clk); #3;
    while (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      checks++;
      if (cpsr_o !== it.cpsr || xfer_rdata !== it.rdata || r15_view !== it.r15) begin
        fails++;
        $display("FAIL %s: cpsr=%h/%h rdata=%h/%h r15=%h/%h (actual/expected)",
                 it.tag, cpsr_o, it.cpsr, xfer_rdata, it.rdata, r15_view, it.r15);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    e_cur = 32'h0000_00D3;
    for (int i = 0; i < 5; i++) e_sav[i] = 32'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    idle("R1 reset state, saved read", 1, 32'h0000_1000);
    idle("R1 R8 reset current read, 32-bit r15", 0, 32'h8765_4320);
    op("R2 flag update", 1, 4'hA, 0, 0, 0, 0, 0, 0, 32'h0);
    op("R6 write SVC saved", 0, 0, 0, 0, 0, 1, 1, 32'h6000_0010, 32'h0);
    idle("R6 read SVC saved", 1, 32'h0);
    op("R5 write current with stray bits", 0, 0, 0, 0, 0, 1, 0, 32'hF000_0FD3, 32'h0);
    op("R5 illegal mode keeps mode", 0, 0, 0, 0, 0, 1, 0, 32'h3000_0015, 32'h0);
    op("R3 IRQ entry", 0, 0, 1, 5'b10010, 0, 0, 0, 0, 32'h0);
    idle("R3 IRQ saved holds old status", 1, 32'h0);
    op("R6 R10 write IRQ saved, illegal mode", 0, 0, 0, 0, 0, 1, 1, 32'h1234_5678, 32'h0);
    idle("R6 read IRQ saved", 1, 32'h0);
    op("R4 return from IRQ", 0, 0, 0, 0, 1, 0, 0, 0, 32'h0);
    idle("R10 SVC saved untouched", 1, 32'h0);
    op("R9 entry beats all", 1, 4'h5, 1, 5'b10001, 1, 1, 0, 32'h0000_0013, 32'h0);
    idle("R3 FIQ saved", 1, 32'h0);
    op("R9 transfer beats flags", 1, 4'h9, 0, 0, 0, 1, 0, 32'h4000_0091, 32'h0);
    op("R3 invalid target ignored, flags apply", 1, 4'h6, 1, 5'b10000, 0, 0, 0, 0, 32'h0);
    op("R4 return from FIQ", 0, 0, 0, 0, 1, 0, 0, 0, 32'h0);
    op("R5 enter user mode", 0, 0, 0, 0, 0, 1, 0, 32'h0000_0010, 32'h0);
    op("R7 user write current flags only", 0, 0, 0, 0, 0, 1, 0, 32'hF000_00D3, 32'h0);
    op("R7 user saved write ignored", 0, 0, 0, 0, 0, 1, 1, 32'hFFFF_FFFF, 32'h0);
    op("R7 user return ignored", 0, 0, 0, 0, 1, 0, 1, 0, 32'h0);
    op("R3 SVC entry from user", 0, 0, 1, 5'b10011, 0, 0, 0, 0, 32'h0);
    idle("R3 SVC saved holds user status", 1, 32'h0);
    op("R5 R8 enter SVC26", 0, 0, 0, 0, 0, 1, 0, 32'hA000_0083, 32'h0012_345C);
    idle("R8 SVC26 fold", 0, 32'hFFFF_FFFF);
    idle("R7 SVC26 saved read zero", 1, 32'h0000_0008);
    op("R4 return ignored in SVC26", 0, 0, 0, 0, 1, 0, 0, 0, 32'h0000_0100);
    op("R8 enter USR26", 0, 0, 0, 0, 0, 1, 0, 32'h5000_0000, 32'h03FF_FFFC);
    op("R7 USR26 mask write ignored", 1, 4'h3, 0, 0, 0, 1, 0, 32'hC000_00C3, 32'h0000_0004);

    repeat (3) @(posedge clk);
    #5;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule